// File: doc/BRIEF.md
# Chunked Hamming Page ECC Generator and Checker

This block protects a NAND page that passes through it as a byte stream. The page is cut into 512-byte chunks. The caller picks 1, 2 or 4 chunks per page, and a number of free spare bytes. In generate mode the block passes the data chunks straight through. It then inserts a 6-byte Hamming digest for each chunk, all digests grouped together, and then passes on the free spare bytes. The result is the order a flash controller writes.

Each digest holds two 3-byte line/column parity codes, one for each 256-byte half of a chunk. In check mode the block takes a page in the same controller order and recomputes every digest. It compares each one with the stored copy and reports one status per chunk:

- clean;
- corrected, with the flipped bit's position;
- uncorrectable;
- damaged digest bytes.

Both streams use valid/ready handshakes. A one-cycle start pulse latches the configuration for a page.

Top module: `necc_page_gen`

## Requirements
- R1: A start pulse (`sop`) is taken only while no page is in progress. It starts a page when `cfg_chunks` is 1, 2 or 4. Any other value raises `cfg_err`, keeps `in_ready` low and produces no output. `cfg_err` stays high until a start pulse is accepted.
- R2: In generate mode the first 512×N input bytes leave unchanged and in order, where N is the chunk count.
- R3: The 6N digest bytes follow the data directly, in chunk order. For chunk c, bytes 0–2 code its first half and bytes 3–5 its second half.
  - Code byte 0, bit k: XOR of the bit-parities of every byte in the half whose offset has bit k clear.
  - Code byte 1, bit k: the same XOR, for offsets with bit k set.
  - Code byte 2: bits 7:5 hold, for j = 0..2, the XOR of the column bits i with bit j of i set. Bits 4:2 hold the same for bit j clear. Column bit i is the XOR of bit i over the whole half. Bits 1:0 are 1.
- R4: The free spare bytes (`cfg_spare` of them) follow the last digest byte unchanged. `out_last` marks the final byte of the page, which is the last digest byte when `cfg_spare` is 0.
- R5: No input is accepted while digests are being emitted. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. No byte is lost or repeated.
- R6: In check mode the input is consumed as data, digests, then spare. `out_valid` stays low. One `stat_valid` pulse per chunk is issued in chunk order, with `stat_chunk` giving the chunk index.
- R7: Status code 00 (clean) is reported when the recomputed digest matches the stored one. Digest pad bits (byte 2, bits 1:0 of each half) are ignored.
- R8: A single flipped data bit in a chunk gives code 01 (corrected). `stat_pos` then reads {half, byte offset in half [7:0], bit [2:0]}. In every other case `stat_pos` is zero.
- R9: Two flipped data bits in one chunk, in the same half or in different halves, give code 10 (uncorrectable).
- R10: A single flipped non-pad bit in a chunk's digest bytes, with clean data, gives code 11 (digest error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop | input | 1 | Start-of-page pulse; latches configuration |
| cfg_check | input | 1 | 1 = check a read page, 0 = generate digests |
| cfg_chunks | input | 3 | Chunks per page (1, 2 or 4) |
| cfg_spare | input | 8 | Free spare byte count |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the page |
| out_ready | input | 1 | Downstream accepts the output byte |
| cfg_err | output | 1 | Last start pulse carried an illegal chunk count |
| stat_valid | output | 1 | Per-chunk status strobe (check mode) |
| stat_chunk | output | 2 | Chunk index of the status |
| stat_code | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 digest error |
| stat_pos | output | 12 | Corrected bit position {half, offset, bit} |

## Verification
The bench builds the block with its default parameters:
- 512-byte chunks, so every byte offset and the half bit appear in `stat_pos`;
- up to four chunks, so each legal count and the illegal counts 0 and 3 can be driven;
- an 8-bit spare count, so empty and non-empty spare areas are both covered.

Pages run with and without random output backpressure. Errors are injected at offset 0, at the last offset of a chunk, across the two halves, and in digest pad and non-pad bits.

// File: rtl/necc_pkg.sv
package necc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_UNCORR = 2'b10,
    ST_ECCERR = 2'b11
  } chunk_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DATA,
    PH_DIG,
    PH_SPARE
  } phase_e;

  localparam int DIG_BYTES = 6;
  localparam int CODE_W    = 24;
endpackage

// File: rtl/necc_half_acc.sv
module necc_half_acc #(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [AW-1:0]     ofs,
  input  logic [7:0]        din,
  output logic [23:0]       code
);
  logic [7:0]    colp, colp_n;
  logic [AW-1:0] lp0, lp1, lp0_n, lp1_n;
  logic          rp;
  logic          fresh;

  // Offset zero restarts the half, so no separate clear is needed.
  always_comb begin
    fresh  = (ofs == '0);
    rp     = ^din;
    colp_n = (fresh ? 8'h00 : colp) ^ din;
    for (int k = 0; k < AW; k++) begin
      lp1_n[k] = (fresh ? 1'b0 : lp1[k]) ^ (rp & ofs[k]);
      lp0_n[k] = (fresh ? 1'b0 : lp0[k]) ^ (rp & ~ofs[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colp <= '0;
      lp0  <= '0;
      lp1  <= '0;
    end else if (en) begin
      colp <= colp_n;
      lp0  <= lp0_n;
      lp1  <= lp1_n;
    end
  end

  always_comb begin
    code = '1;
    code[AW-1:0]  = lp0;
    code[8 +: AW] = lp1;
    for (int j = 0; j < 3; j++) begin
      code[21+j] = 1'b0;
      code[18+j] = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (((i >> j) & 1) == 1) code[21+j] = code[21+j] ^ colp[i];
        else                     code[18+j] = code[18+j] ^ colp[i];
      end
    end
  end
endmodule

// File: rtl/necc_synd.sv
module necc_synd
  import necc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [23:0]   calc,
  input  logic [23:0]   recv,
  output chunk_stat_e   kind,
  output logic [AW-1:0] bofs,
  output logic [2:0]    bpos
);
  logic [23:0] s;
  logic        pairs_ok;

  always_comb begin
    s = calc ^ recv;
    s[17:16] = 2'b00;
    for (int i = AW; i < 8; i++) begin
      s[i]   = 1'b0;
      s[8+i] = 1'b0;
    end
    pairs_ok = 1'b1;
    for (int k = 0; k < AW; k++)
      if (s[k] == s[8+k]) pairs_ok = 1'b0;
    for (int j = 0; j < 3; j++)
      if (s[18+j] == s[21+j]) pairs_ok = 1'b0;
    if (s == '0)                kind = ST_CLEAN;
    else if ($countones(s) == 1) kind = ST_ECCERR;
    else if (pairs_ok)          kind = ST_FIXED;
    else                        kind = ST_UNCORR;
    bofs = s[8 +: AW];
    bpos = s[23:21];
  end
endmodule

// File: rtl/necc_page_gen.sv
module necc_page_gen
  import necc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int MAX_CHUNKS  = 4,
  parameter int SPW         = 8,
  localparam int HALF  = CHUNK_BYTES / 2,
  localparam int AW    = $clog2(HALF),
  localparam int NHALF = 2 * MAX_CHUNKS,
  localparam int HW    = $clog2(NHALF),
  localparam int CW    = $clog2(MAX_CHUNKS),
  localparam int CFGW  = CW + 1,
  localparam int POSW  = AW + 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sop,
  input  logic            cfg_check,
  input  logic [CFGW-1:0] cfg_chunks,
  input  logic [SPW-1:0]  cfg_spare,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  input  logic            out_ready,
  output logic            cfg_err,
  output logic            stat_valid,
  output logic [CW-1:0]   stat_chunk,
  output logic [1:0]      stat_code,
  output logic [POSW-1:0] stat_pos
);
  phase_e          phase;
  logic            chk_q;
  logic [CFGW-1:0] nch_q;
  logic [SPW-1:0]  nsp_q;
  logic [AW-1:0]   bcnt;
  logic [HW:0]     hcnt;
  logic [2:0]      dig_byte;
  logic [CW-1:0]   dig_chunk;
  logic [SPW-1:0]  spcnt;
  logic            half_done;
  logic [HW-1:0]   done_idx;
  logic [47:0]     recv48;
  logic            eval_pend;
  logic [CW-1:0]   eval_chunk;
  logic [23:0]     dig_mem [NHALF];

  logic            legal, can_load, fire, data_fire;
  logic [HW:0]     last_half;
  logic            last_chunk, dig_hi;
  logic [1:0]      bsel;
  logic [23:0]     acc_code, dig_word;
  logic [7:0]      dig_out;

  always_comb begin
    legal = (cfg_chunks != '0) && ((cfg_chunks & (cfg_chunks - 1'b1)) == '0)
            && (cfg_chunks <= CFGW'(MAX_CHUNKS));
    can_load   = !out_valid || out_ready;
    last_half  = {nch_q, 1'b0} - (HW+1)'(1);
    last_chunk = (dig_chunk == CW'(nch_q - 1'b1));
    dig_hi     = (dig_byte >= 3'd3);
    bsel       = dig_hi ? 2'(dig_byte - 3'd3) : dig_byte[1:0];
    dig_word   = dig_mem[{dig_chunk, dig_hi}];
    dig_out    = dig_word[{bsel, 3'b000} +: 8];
    case (phase)
      PH_DATA, PH_SPARE: in_ready = chk_q ? 1'b1 : can_load;
      PH_DIG:            in_ready = chk_q;
      default:           in_ready = 1'b0;
    endcase
    fire      = in_valid && in_ready;
    data_fire = fire && (phase == PH_DATA);
  end

  necc_half_acc #(.AW(AW)) u_acc (
    .clk(clk), .rst(rst), .en(data_fire), .ofs(bcnt), .din(in_data), .code(acc_code)
  );

  // Digest store: written once per half, no reset, so it can map to RAM.
  always_ff @(posedge clk) begin
    if (half_done) dig_mem[done_idx] <= acc_code;
  end

  chunk_stat_e   k0, k1, kc;
  logic [AW-1:0] o0, o1;
  logic [2:0]    p0, p1;
  logic [POSW-1:0] pc;

  necc_synd #(.AW(AW)) u_syn0 (
    .calc(dig_mem[{eval_chunk, 1'b0}]), .recv(recv48[23:0]), .kind(k0), .bofs(o0), .bpos(p0)
  );
  necc_synd #(.AW(AW)) u_syn1 (
    .calc(dig_mem[{eval_chunk, 1'b1}]), .recv(recv48[47:24]), .kind(k1), .bofs(o1), .bpos(p1)
  );

  always_comb begin
    pc = '0;
    if (k0 == ST_UNCORR || k1 == ST_UNCORR)      kc = ST_UNCORR;
    else if (k0 != ST_CLEAN && k1 != ST_CLEAN)   kc = ST_UNCORR;
    else if (k0 != ST_CLEAN) begin
      kc = k0;
      if (k0 == ST_FIXED) pc = {1'b0, o0, p0};
    end else if (k1 != ST_CLEAN) begin
      kc = k1;
      if (k1 == ST_FIXED) pc = {1'b1, o1, p1};
    end else                                     kc = ST_CLEAN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;  chk_q <= 1'b0;  nch_q <= '0;  nsp_q <= '0;
      bcnt <= '0;  hcnt <= '0;  dig_byte <= '0;  dig_chunk <= '0;  spcnt <= '0;
      half_done <= 1'b0;  done_idx <= '0;  recv48 <= '0;
      eval_pend <= 1'b0;  eval_chunk <= '0;
      out_valid <= 1'b0;  out_data <= '0;  out_last <= 1'b0;  cfg_err <= 1'b0;
      stat_valid <= 1'b0;  stat_chunk <= '0;  stat_code <= '0;  stat_pos <= '0;
    end else begin
      half_done  <= 1'b0;
      eval_pend  <= 1'b0;
      stat_valid <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (phase)
        PH_IDLE: if (sop) begin
          if (legal) begin
            phase <= PH_DATA;  chk_q <= cfg_check;  nch_q <= cfg_chunks;
            nsp_q <= cfg_spare;  bcnt <= '0;  hcnt <= '0;  dig_byte <= '0;
            dig_chunk <= '0;  spcnt <= '0;  cfg_err <= 1'b0;
          end else cfg_err <= 1'b1;
        end
        PH_DATA: if (fire) begin
          if (!chk_q) begin
            out_valid <= 1'b1;  out_data <= in_data;  out_last <= 1'b0;
          end
          bcnt <= bcnt + 1'b1;
          if (bcnt == AW'(HALF - 1)) begin
            half_done <= 1'b1;
            done_idx  <= hcnt[HW-1:0];
            hcnt      <= hcnt + 1'b1;
            if (hcnt == last_half) phase <= PH_DIG;
          end
        end
        PH_DIG: if (chk_q ? fire : can_load) begin
          if (chk_q) begin
            recv48[{dig_byte, 3'b000} +: 8] <= in_data;
            if (dig_byte == 3'd5) begin
              eval_pend  <= 1'b1;
              eval_chunk <= dig_chunk;
            end
          end else begin
            out_valid <= 1'b1;
            out_data  <= dig_out;
            out_last  <= last_chunk && (dig_byte == 3'd5) && (nsp_q == '0);
          end
          if (dig_byte == 3'd5) begin
            dig_byte  <= '0;
            dig_chunk <= dig_chunk + 1'b1;
            if (last_chunk) phase <= (nsp_q == '0) ? PH_IDLE : PH_SPARE;
          end else dig_byte <= dig_byte + 1'b1;
        end
        PH_SPARE: if (fire) begin
          if (!chk_q) begin
            out_valid <= 1'b1;  out_data <= in_data;
            out_last  <= (spcnt == nsp_q - 1'b1);
          end
          spcnt <= spcnt + 1'b1;
          if (spcnt == nsp_q - 1'b1) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
      if (eval_pend) begin
        stat_valid <= 1'b1;
        stat_chunk <= eval_chunk;
        stat_code  <= kc;
        stat_pos   <= pc;
      end
    end
  end

  AST_BAD_CFG_REJECT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && sop && !legal) |=> (cfg_err && !in_ready)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R5
  AST_DIG_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DIG && !chk_q) |-> !in_ready); // R5
  AST_CHECK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (chk_q && phase != PH_IDLE) |=> !$rose(out_valid)); // R6
  AST_STAT_SPACED: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid); // R6
  AST_POS_ONLY_FIXED: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_code != 2'b01) |-> (stat_pos == '0)); // R8
endmodule

// File: tb/necc_page_gen_tb.sv
module necc_page_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sop = 1'b0, cfg_check = 1'b0;
  logic [2:0]  cfg_chunks = 3'd1;
  logic [7:0]  cfg_spare = 8'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, out_valid, out_last, cfg_err, stat_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic [1:0]  stat_chunk, stat_code;
  logic [11:0] stat_pos;

  necc_page_gen u_dut (
    .clk(clk), .rst(rst), .sop(sop), .cfg_check(cfg_check), .cfg_chunks(cfg_chunks),
    .cfg_spare(cfg_spare), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .cfg_err(cfg_err), .stat_valid(stat_valid), .stat_chunk(stat_chunk),
    .stat_code(stat_code), .stat_pos(stat_pos)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, spurious = 0;
  logic bp = 1'b0, chk_active = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] dat [0:2047];
  logic [7:0] dgb [0:23];
  logic [10:0] exp_q [$];   // {kind[1:0], last, data}
  logic [15:0] st_q  [$];   // {chunk, code, pos}

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (chk_active && out_valid) spurious++;
    if (out_valid && out_ready && !chk_active) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected output byte", out_data, -1);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        case (e[10:9])
          2'd0: chk({out_last, out_data} == e[8:0], "R2 data byte", {out_last, out_data}, e[8:0]);
          2'd1: chk({out_last, out_data} == e[8:0], "R3 digest byte / R4 last", {out_last, out_data}, e[8:0]);
          default: chk({out_last, out_data} == e[8:0], "R4 spare byte", {out_last, out_data}, e[8:0]);
        endcase
      end
    end
    if (stat_valid) begin
      if (st_q.size() == 0) chk(1'b0, "R6 unexpected status", stat_code, -1);
      else begin
        logic [15:0] s;
        s = st_q.pop_front();
        chk(stat_chunk == s[15:14], "R6 chunk order", stat_chunk, s[15:14]);
        case (s[13:12])
          2'b00: chk({stat_code, stat_pos} == s[13:0], "R7 clean status", {stat_code, stat_pos}, s[13:0]);
          2'b01: chk({stat_code, stat_pos} == s[13:0], "R8 corrected status", {stat_code, stat_pos}, s[13:0]);
          2'b10: chk({stat_code, stat_pos} == s[13:0], "R9 uncorrectable status", {stat_code, stat_pos}, s[13:0]);
          default: chk({stat_code, stat_pos} == s[13:0], "R10 digest error status", {stat_code, stat_pos}, s[13:0]);
        endcase
      end
    end
  end

  function automatic logic [23:0] ref_code(input int base);
    logic [7:0] col = 8'h00, l0 = 8'h00, l1 = 8'h00;
    logic [23:0] c;
    for (int a = 0; a < 256; a++) begin
      col ^= dat[base + a];
      for (int k = 0; k < 8; k++) begin
        if (a[k]) l1[k] ^= ^dat[base + a];
        else      l0[k] ^= ^dat[base + a];
      end
    end
    c = {8'h03, l1, l0};
    for (int j = 0; j < 3; j++) begin
      c[21+j] = 1'b0; c[18+j] = 1'b0;
      for (int i = 0; i < 8; i++)
        if (i[j]) c[21+j] ^= col[i]; else c[18+j] ^= col[i];
    end
    return c;
  endfunction

  task automatic fill(input int nch, input int seed);
    for (int i = 0; i < nch * 512; i++) dat[i] = 8'((i * 37) + (seed * 11) + (i >> 8) + (i >> 5));
    for (int c = 0; c < nch; c++)
      for (int h = 0; h < 2; h++) begin
        logic [23:0] cd;
        cd = ref_code(c * 512 + h * 256);
        dgb[c*6 + h*3 + 0] = cd[7:0];
        dgb[c*6 + h*3 + 1] = cd[15:8];
        dgb[c*6 + h*3 + 2] = cd[23:16];
      end
  endtask

  task automatic put_byte(input logic [7:0] b, output int waited);
    waited = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1; waited++;
    end
  endtask

  task automatic start_page(input bit chkm, input int nch, input int nsp);
    @(negedge clk);
    sop = 1'b1; cfg_check = chkm; cfg_chunks = 3'(nch); cfg_spare = 8'(nsp);
    @(negedge clk);
    sop = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || st_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic gen_page(input int nch, input int nsp, input int seed, input bit use_bp);
    int w;
    bp = use_bp;
    fill(nch, seed);
    for (int i = 0; i < nch * 512; i++) exp_q.push_back({2'd0, 1'b0, dat[i]});
    for (int i = 0; i < nch * 6; i++)
      exp_q.push_back({2'd1, (nsp == 0 && i == nch * 6 - 1), dgb[i]});
    for (int i = 0; i < nsp; i++) exp_q.push_back({2'd2, (i == nsp - 1), 8'(8'hA0 + i)});
    start_page(1'b0, nch, nsp);
    for (int i = 0; i < nch * 512; i++) put_byte(dat[i], w);
    for (int i = 0; i < nsp; i++) begin
      put_byte(8'(8'hA0 + i), w);
      if (i == 0) chk(w >= nch * 6, "R5 input held during digests", w, nch * 6);
    end
    @(negedge clk); in_valid = 1'b0;
    drain();
    bp = 1'b0;
    chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
  endtask

  task automatic check_page(input int nch, input int nsp);
    int w;
    chk_active = 1'b1; spurious = 0;
    start_page(1'b1, nch, nsp);
    for (int i = 0; i < nch * 512; i++) put_byte(dat[i], w);
    for (int i = 0; i < nch * 6; i++) put_byte(dgb[i], w);
    for (int i = 0; i < nsp; i++) put_byte(8'(8'h55 ^ i), w);
    @(negedge clk); in_valid = 1'b0;
    drain();
    chk_active = 1'b0;
    chk(spurious == 0, "R6 no output in check mode", spurious, 0);
    chk(st_q.size() == 0, "R6 every status seen", st_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(in_ready == 0, "R1 reset in_ready", in_ready, 0);
    chk(out_valid == 0, "R5 reset out_valid", out_valid, 0);
    chk(cfg_err == 0, "R1 reset cfg_err", cfg_err, 0);
    chk(stat_valid == 0, "R6 reset stat_valid", stat_valid, 0);

    // R1: illegal counts 3 and 0 are rejected
    for (int t = 0; t < 2; t++) begin
      start_page(1'b0, (t == 0) ? 3 : 0, 2);
      @(negedge clk); in_valid = 1'b1; in_data = 8'h77;
      for (int c = 0; c < 4; c++) begin
        #2;
        chk(cfg_err == 1, "R1 cfg_err raised", cfg_err, 1);
        chk(in_ready == 0 && out_valid == 0, "R1 page not processed", {in_ready, out_valid}, 0);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end

    gen_page(1, 5, 1, 1'b0);
    #2 chk(cfg_err == 0, "R1 cfg_err cleared by legal start", cfg_err, 0);
    gen_page(2, 0, 2, 1'b1);
    gen_page(4, 16, 3, 1'b1);

    // Check mode, four chunks: clean, one flip, two flips, digest flip
    fill(4, 4);
    dat[512 + 300] ^= 8'h20;
    dat[1024 + 10] ^= 8'h02;
    dat[1024 + 400] ^= 8'h80;
    dgb[3*6 + 1] ^= 8'h04;
    st_q.push_back({2'd0, 2'b00, 12'd0});
    st_q.push_back({2'd1, 2'b01, 1'b1, 8'd44, 3'd5});
    st_q.push_back({2'd2, 2'b10, 12'd0});
    st_q.push_back({2'd3, 2'b11, 12'd0});
    check_page(4, 3);

    // One chunk, flip at offset 0 bit 0
    fill(1, 5);
    dat[0] ^= 8'h01;
    st_q.push_back({2'd0, 2'b01, 1'b0, 8'd0, 3'd0});
    check_page(1, 0);

    // Two chunks: pad bit flip ignored; last byte of chunk flipped; two flips in one half
    fill(2, 6);
    dgb[2] ^= 8'h01;
    dat[512 + 511] ^= 8'h80;
    st_q.push_back({2'd0, 2'b00, 12'd0});
    st_q.push_back({2'd1, 2'b01, 1'b1, 8'd255, 3'd7});
    check_page(2, 2);

    fill(2, 7);
    dat[20] ^= 8'h10;
    dat[21] ^= 8'h10;
    dgb[6 + 5] ^= 8'h40;
    st_q.push_back({2'd0, 2'b10, 12'd0});
    st_q.push_back({2'd1, 2'b11, 12'd0});
    check_page(2, 0);

    gen_page(4, 0, 8, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule